// File: doc/BRIEF.md
# UART Register Front-End with Receive Queue

This block is the register face of a simple serial port, as software on a bus sees it. It knows nothing of bit timing. Received bytes come in on a valid/ready byte stream and wait in an eight-deep queue. Software drains the queue by reading the receive-data register. Each write to the transmit-data register leaves the block as one byte on an output stream that has no back-pressure.

The bus port is synchronous: one access per cycle, qualified by an enable strobe. The register is chosen by the byte address shifted right by two. Read data is registered and is valid in the cycle after the read strobe. It holds its value until the next read.

The status register reports queue occupancy and a sticky interrupt-pending flag. A single level interrupt output is that flag masked by an enable bit in the control register.

Top module: `uart_regfront`

## Requirements
- R1: The register is selected by address bits [3:2]: 0 is receive data, 1 is transmit data, 2 is status and 3 is control. A read of the transmit or control register returns the full 32-bit value last written there.
- R2: A status read returns the following fields, and zero in every other bit (including 5 to 7):
  - bit 0: the queue holds data.
  - bit 1: the queue holds 8 bytes.
  - bit 2: always 1.
  - bit 3: always 0.
  - bit 4: the pending flag.
- R3: The queue holds 8 bytes. `rx_ready` is low exactly when 8 bytes are held, and a byte offered at that time is not stored.
- R4: A receive-data read returns the oldest held byte, zero-extended, and removes it. A read of an empty queue leaves it empty.
- R5: Writing control with bit 1 set empties the queue, and a byte offered in that cycle is dropped. The written control word is kept.
- R6: A write to the status register changes nothing.
- R7: A transmit-data write puts its low 8 bits on `tx_data`, with `tx_valid` high for exactly the following cycle. The write also sets the pending flag.
- R8: The pending flag is held while the queue holds data. Otherwise it clears only on a status read that has no transmit write and no stored byte in the same cycle.
- R9: `irq` equals the pending flag AND control bit 4.
- R10: A push and a receive-data pop in the same cycle on a non-empty queue leave the occupancy unchanged. On a full queue the pop is honoured and the push is refused.
- R11: After reset:
  - the queue is empty;
  - the pending flag, control and transmit registers are zero;
  - `irq` and `tx_valid` are low, and `rx_ready` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_en | input | 1 | Access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Registered read data |
| rx_valid | input | 1 | Incoming byte offered |
| rx_data | input | BYTE_W | Incoming byte |
| rx_ready | output | 1 | Queue can accept a byte |
| tx_valid | output | 1 | Outgoing byte strobe |
| tx_data | output | BYTE_W | Outgoing byte |
| irq | output | 1 | Level interrupt |

## Verification
Three pairs of actions can land in the same cycle:
- a byte arriving on the stream and a bus read popping the queue;
- a byte arriving and a control write that empties the queue;
- a status read that clears the pending flag and a data arrival that sets it again.

The bench offers incoming bytes in the very cycles that carry these bus accesses, on an empty, a partly filled and a full queue. A queue-based reference model judges the result. Occupancy and order are seen through `rx_ready`, the status word and the bytes drained afterwards.

// File: rtl/uart_regfront_pkg.sv
package uart_regfront_pkg;
  typedef enum logic [1:0] {
    REG_RXD  = 2'd0,
    REG_TXD  = 2'd1,
    REG_STAT = 2'd2,
    REG_CTRL = 2'd3
  } reg_sel_e;

  localparam int ST_AVAIL   = 0;
  localparam int ST_FULL    = 1;
  localparam int ST_TXEMPTY = 2;
  localparam int ST_TXFULL  = 3;
  localparam int ST_PEND    = 4;

  localparam int CT_TXCLR = 0;
  localparam int CT_RXCLR = 1;
  localparam int CT_IE    = 4;
endpackage

// File: rtl/rfe_rx_fifo.sv
module rfe_rx_fifo #(
  parameter int DEPTH = 8,
  parameter int DW    = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          push_valid,
  input  logic [DW-1:0] push_data,
  input  logic          pop,
  output logic          ready,
  output logic          full,
  output logic          nonempty,
  output logic          nonempty_nx,
  output logic [DW-1:0] head_data
);
  localparam int PW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [CW-1:0] CNT_FULL = CW'(DEPTH);

  logic [DW-1:0] mem [DEPTH];
  logic [PW-1:0] wpos_q, wpos_nx, rd_idx;
  logic [CW-1:0] count_q, count_nx;
  logic          push_ok, dec;

  assign full      = (count_q == CNT_FULL);
  assign nonempty  = (count_q != '0);
  assign ready     = ~full;
  assign push_ok   = push_valid & ~full & ~clr;
  assign dec       = pop & nonempty;
  assign rd_idx    = wpos_q - count_q[PW-1:0];
  assign head_data = mem[rd_idx];

  always_comb begin
    wpos_nx  = wpos_q;
    count_nx = count_q;
    if (clr) begin
      wpos_nx  = '0;
      count_nx = '0;
    end else begin
      if (push_ok) wpos_nx = wpos_q + 1'b1;
      case ({push_ok, dec})
        2'b10:   count_nx = count_q + 1'b1;
        2'b01:   count_nx = count_q - 1'b1;
        default: count_nx = count_q;
      endcase
    end
  end

  assign nonempty_nx = (count_nx != '0);

  always_ff @(posedge clk) begin
    if (push_ok) mem[wpos_q] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wpos_q  <= '0;
      count_q <= '0;
    end else begin
      wpos_q  <= wpos_nx;
      count_q <= count_nx;
    end
  end

  assert_no_overflow_R3: assert property (@(posedge clk) disable iff (rst)
    count_q <= CNT_FULL);
  assert_full_refuse_R3: assert property (@(posedge clk) disable iff (rst)
    (full && push_valid && !pop && !clr) |=> (count_q == CNT_FULL) && $stable(wpos_q));
  assert_pushpop_R10: assert property (@(posedge clk) disable iff (rst)
    (push_valid && pop && !full && nonempty && !clr) |=> $stable(count_q));
  assert_full_pop_R10: assert property (@(posedge clk) disable iff (rst)
    (full && push_valid && pop && !clr) |=> count_q == CW'(DEPTH - 1));
  assert_empty_pop_R4: assert property (@(posedge clk) disable iff (rst)
    (pop && !nonempty && !push_valid && !clr) |=> count_q == '0);
endmodule

// File: rtl/rfe_tx_out.sv
module rfe_tx_out #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr,
  input  logic [DW-1:0] wbyte,
  output logic          tx_valid,
  output logic [DW-1:0] tx_data
);
  always_ff @(posedge clk) begin
    if (rst) begin
      tx_valid <= 1'b0;
      tx_data  <= '0;
    end else begin
      tx_valid <= wr;
      if (wr) tx_data <= wbyte;
    end
  end

  assert_tx_pulse_R7: assert property (@(posedge clk) disable iff (rst)
    wr |=> tx_valid && (tx_data == $past(wbyte)));
  assert_tx_single_R7: assert property (@(posedge clk) disable iff (rst)
    !wr |=> !tx_valid);
endmodule

// File: rtl/rfe_irq_ctrl.sv
module rfe_irq_ctrl (
  input  logic clk,
  input  logic rst,
  input  logic stat_rd,
  input  logic tx_wr,
  input  logic nonempty_nx,
  input  logic ie_nx,
  output logic pending,
  output logic irq
);
  logic pend_nx;

  assign pend_nx = (pending & ~stat_rd) | tx_wr | nonempty_nx;

  always_ff @(posedge clk) begin
    if (rst) begin
      pending <= 1'b0;
      irq     <= 1'b0;
    end else begin
      pending <= pend_nx;
      irq     <= pend_nx & ie_nx;
    end
  end

  assert_tx_sets_pend_R7: assert property (@(posedge clk) disable iff (rst)
    tx_wr |=> pending);
  assert_sticky_R8: assert property (@(posedge clk) disable iff (rst)
    (pending && !stat_rd) |=> pending);
endmodule

// File: rtl/uart_regfront.sv
module uart_regfront
  import uart_regfront_pkg::*;
#(
  parameter int ADDR_W   = 4,
  parameter int DATA_W   = 32,
  parameter int BYTE_W   = 8,
  parameter int RX_DEPTH = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_en,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              rx_valid,
  input  logic [BYTE_W-1:0] rx_data,
  output logic              rx_ready,
  output logic              tx_valid,
  output logic [BYTE_W-1:0] tx_data,
  output logic              irq
);
  localparam int SEL_LSB = 2;
  localparam int SEL_W   = 2;
  localparam int SPAN_W  = SEL_LSB + SEL_W;

  reg_sel_e          sel;
  logic              in_rng;
  logic              acc_rd, acc_wr;
  logic              rx_pop, stat_rd, stat_wr, tx_wr, ctrl_wr, rx_clr;
  logic [DATA_W-1:0] ctrl_q, ctrl_nx, txreg_q, stat_vec;
  logic              q_full, q_nonempty, q_nonempty_nx, pend;
  logic [BYTE_W-1:0] head_byte;
  logic [SEL_LSB-1:0] unused_lsb;

  assign unused_lsb = bus_addr[SEL_LSB-1:0];
  assign sel = reg_sel_e'(bus_addr[SPAN_W-1:SEL_LSB]);

  generate
    if (ADDR_W > SPAN_W) begin : g_hi_dec
      assign in_rng = (bus_addr[ADDR_W-1:SPAN_W] == '0);
    end else begin : g_no_hi
      assign in_rng = 1'b1;
    end
  endgenerate

  assign acc_rd  = bus_en & ~bus_we & in_rng;
  assign acc_wr  = bus_en &  bus_we & in_rng;
  assign rx_pop  = acc_rd & (sel == REG_RXD);
  assign stat_rd = acc_rd & (sel == REG_STAT);
  assign stat_wr = acc_wr & (sel == REG_STAT);
  assign tx_wr   = acc_wr & (sel == REG_TXD);
  assign ctrl_wr = acc_wr & (sel == REG_CTRL);
  assign rx_clr  = ctrl_wr & bus_wdata[CT_RXCLR];
  assign ctrl_nx = ctrl_wr ? bus_wdata : ctrl_q;

  rfe_rx_fifo #(.DEPTH(RX_DEPTH), .DW(BYTE_W)) u_fifo (
    .clk(clk), .rst(rst), .clr(rx_clr),
    .push_valid(rx_valid), .push_data(rx_data), .pop(rx_pop),
    .ready(rx_ready), .full(q_full), .nonempty(q_nonempty),
    .nonempty_nx(q_nonempty_nx), .head_data(head_byte)
  );

  rfe_tx_out #(.DW(BYTE_W)) u_tx (
    .clk(clk), .rst(rst), .wr(tx_wr), .wbyte(bus_wdata[BYTE_W-1:0]),
    .tx_valid(tx_valid), .tx_data(tx_data)
  );

  rfe_irq_ctrl u_irq (
    .clk(clk), .rst(rst), .stat_rd(stat_rd), .tx_wr(tx_wr),
    .nonempty_nx(q_nonempty_nx), .ie_nx(ctrl_nx[CT_IE]),
    .pending(pend), .irq(irq)
  );

  always_comb begin
    stat_vec              = '0;
    stat_vec[ST_AVAIL]    = q_nonempty;
    stat_vec[ST_FULL]     = q_full;
    stat_vec[ST_TXEMPTY]  = 1'b1;
    stat_vec[ST_TXFULL]   = 1'b0;
    stat_vec[ST_PEND]     = pend;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q    <= '0;
      txreg_q   <= '0;
      bus_rdata <= '0;
    end else begin
      ctrl_q <= ctrl_nx;
      if (tx_wr) txreg_q <= bus_wdata;
      if (acc_rd) begin
        case (sel)
          REG_RXD:  bus_rdata <= {{(DATA_W-BYTE_W){1'b0}}, head_byte};
          REG_TXD:  bus_rdata <= txreg_q;
          REG_STAT: bus_rdata <= stat_vec;
          default:  bus_rdata <= ctrl_q;
        endcase
      end
    end
  end

  assert_irq_gate_R9: assert property (@(posedge clk) disable iff (rst)
    irq == (pend && ctrl_q[CT_IE]));
  assert_pend_on_data_R8: assert property (@(posedge clk) disable iff (rst)
    q_nonempty |-> pend);
  assert_stat_wr_ignored_R6: assert property (@(posedge clk) disable iff (rst)
    stat_wr |=> $stable(ctrl_q) && $stable(txreg_q));
  assert_ready_full_R3: assert property (@(posedge clk) disable iff (rst)
    rx_ready != q_full);
endmodule

// File: tb/uart_regfront_tb.sv
module uart_regfront_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_en = 1'b0, bus_we = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        rx_valid = 1'b0;
  logic [7:0]  rx_data = '0;
  logic        rx_ready, tx_valid, irq;
  logic [7:0]  tx_data;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  // reference model state
  byte unsigned q[$];
  bit           m_pend = 1'b0;
  logic [31:0]  m_ctrl = '0, m_tx = '0;

  always #2 clk = ~clk;

  uart_regfront u_dut (
    .clk(clk), .rst(rst), .bus_en(bus_en), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .rx_valid(rx_valid), .rx_data(rx_data), .rx_ready(rx_ready),
    .tx_valid(tx_valid), .tx_data(tx_data), .irq(irq)
  );

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  function automatic logic [31:0] m_status();
    logic [31:0] s = 32'h4;
    s[0] = (q.size() != 0);
    s[1] = (q.size() == 8);
    s[4] = m_pend;
    return s;
  endfunction

  // one bus/stream cycle: drive at negedge, model, compare at next negedge
  task automatic cyc(input bit en, input bit we, input logic [3:0] addr,
                     input logic [31:0] wd, input bit rv, input logic [7:0] rb,
                     input string tag);
    bit          rdf, wrf, chk_rd, txv, clr, acc;
    int          sel;
    logic [31:0] exp_rd;
    logic [7:0]  exp_txd;
    bus_en = en; bus_we = we; bus_addr = addr; bus_wdata = wd;
    rx_valid = rv; rx_data = rb;
    rdf = en && !we; wrf = en && we; sel = int'(addr[3:2]);
    acc = rv && (q.size() < 8);
    chk_rd = 1'b0; txv = 1'b0; clr = 1'b0; exp_rd = '0; exp_txd = '0;
    if (rdf) begin
      chk_rd = 1'b1;
      case (sel)
        0: if (q.size() > 0) exp_rd = {24'h0, q.pop_front()}; else chk_rd = 1'b0;
        1: exp_rd = m_tx;
        2: exp_rd = m_status();
        default: exp_rd = m_ctrl;
      endcase
    end
    if (wrf) begin
      if (sel == 1) begin m_tx = wd; txv = 1'b1; exp_txd = wd[7:0]; end
      if (sel == 3) begin
        m_ctrl = wd;
        if (wd[1]) begin q.delete(); clr = 1'b1; end
      end
    end
    if (acc && !clr) q.push_back(rb);
    m_pend = (m_pend && !(rdf && sel == 2)) || txv || (q.size() != 0);
    @(posedge clk);
    @(negedge clk);
    chk(rx_ready == (q.size() < 8), {"R3 ", tag}, "rx_ready", 32'(rx_ready), 32'(q.size() < 8));
    chk(irq == (m_pend && m_ctrl[4]), {"R9 ", tag}, "irq", 32'(irq), 32'(m_pend && m_ctrl[4]));
    chk(tx_valid == txv, {"R7 ", tag}, "tx_valid", 32'(tx_valid), 32'(txv));
    if (txv) chk(tx_data == exp_txd, {"R7 ", tag}, "tx_data", 32'(tx_data), 32'(exp_txd));
    if (chk_rd) chk(bus_rdata == exp_rd, tag, "rdata", bus_rdata, exp_rd);
    bus_en = 1'b0; rx_valid = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, input string tag);
    cyc(1, 0, a, '0, 0, '0, tag);
  endtask
  task automatic wr(input logic [3:0] a, input logic [31:0] d, input string tag);
    cyc(1, 1, a, d, 0, '0, tag);
  endtask
  task automatic push(input logic [7:0] b, input string tag);
    cyc(0, 0, '0, '0, 1, b, tag);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R11 reset state
    chk(rx_ready == 1'b1, "R11", "rx_ready", 32'(rx_ready), 1);
    chk(irq == 1'b0, "R11", "irq", 32'(irq), 0);
    chk(tx_valid == 1'b0, "R11", "tx_valid", 32'(tx_valid), 0);
    rd(4'h8, "R11_R2 status");
    rd(4'hC, "R11 ctrl");
    rd(4'h4, "R11 txreg");
    // R1 R5 control readback, R9 enable
    wr(4'hC, 32'hABCD_0010, "R5 ctrl write");
    rd(4'hC, "R1 ctrl readback");
    // R7 transmit
    wr(4'h4, 32'h1234_01A5, "R7 tx write");
    rd(4'h4, "R1 tx readback");
    rd(4'h8, "R8 status pend set");
    rd(4'h8, "R8 status pend cleared");
    // R3 R4 queue order
    push(8'h11, "R3 push"); push(8'h22, "R3 push"); push(8'h33, "R3 push");
    rd(4'h8, "R8 status nonempty keeps pend");
    rd(4'h8, "R2 status again");
    rd(4'h0, "R4 pop"); rd(4'h0, "R4 pop"); rd(4'h0, "R4 pop");
    rd(4'h0, "R4 empty pop");
    rd(4'h8, "R4 status after empty pop");
    // R8 status read coinciding with arrival
    cyc(1, 0, 4'h8, '0, 1, 8'h5A, "R8 stat read with push");
    rd(4'h8, "R8 pend re-set");
    rd(4'h0, "R4 pop 5A");
    // R10 push and pop on empty queue
    cyc(1, 0, 4'h0, '0, 1, 8'h66, "R10 push pop empty");
    rd(4'h0, "R10 pop 66");
    // fill to 8, ninth refused
    for (int i = 0; i < 9; i++) push(8'(8'h80 + i), "R3 fill");
    rd(4'h8, "R2 full status");
    cyc(1, 0, 4'h0, '0, 1, 8'hEE, "R10 full pop push refused");
    cyc(1, 0, 4'h0, '0, 1, 8'hC1, "R10 push pop count 7");
    // R6 status write ignored
    wr(4'h8, 32'hFFFF_FFFF, "R6 status write");
    rd(4'h8, "R6 status unchanged");
    rd(4'hC, "R6 ctrl unchanged");
    rd(4'h4, "R6 tx unchanged");
    for (int i = 0; i < 7; i++) rd(4'h0, "R10 drain order");
    rd(4'h8, "R4 drained status");
    // R5 clear with pending data and a push in the same cycle
    push(8'h01, "R5 prefill"); push(8'h02, "R5 prefill");
    cyc(1, 1, 4'hC, 32'h0000_0012, 1, 8'h03, "R5 clear with push");
    rd(4'h8, "R5 status after clear");
    rd(4'h8, "R5 status second");
    push(8'h44, "R5 after clear");
    rd(4'h0, "R5 pop after clear");
    // R9 enable off with pending set
    wr(4'h4, 32'h0000_0077, "R7 tx second");
    wr(4'hC, 32'h0, "R9 ie off");
    rd(4'h8, "R9 status pend while masked");
    wr(4'hC, 32'h10, "R9 ie on");
    rd(4'h8, "R8 clear");
    // mixed traffic
    for (int i = 0; i < 300; i++) begin
      int unsigned r = $urandom;
      logic [3:0] a = {r[1:0], 2'b00};
      cyc(r[2], r[3] && (a != 4'hC || !r[9]), a, {24'h0, r[15:8]}, r[4], r[23:16], "R4_R10 mixed");
    end
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule